// File: doc/BRIEF.md
# Pulse-Width Capture with Buffer-Full Interlock

This block times a digital input against a free-running tick. A single counter is cleared on each rising edge of the measured input and advances once per tick. At the end of a measurement the count is moved into a result register and a buffer-full flag is raised. Software, or any bus master, fetches the result through a narrow read port in two halves. Reading the lower half lowers the flag again.

A four-bit mode code picks what is measured. The choices are the high time only, the period only (rising edge to rising edge), or both in turn. While the flag is up, new results are normally discarded, so the value being read cannot change under the reader. In the combined mode a finished high-time result is written even over an unread value. A finished period result is not. The reader must therefore collect the high time before the period closes. Both results are lost if they are still unread when the next high time completes. A bus write can overwrite either half of the result register.

Top module: `pwc_capture`

## Requirements
- R1: The counter is cleared in the cycle where a rising edge of `meas_in` is seen in an active mode. After that it increments once in each cycle with `tick` high, and it holds at its all-ones value instead of wrapping.
- R2: Mode code 4'b0001 measures high time, 4'b0010 measures period, and 4'b1001 measures both. Any other code is idle and produces no result. A cycle in which the code changes abandons any measurement in progress.
- R3: A high-time result equals the number of tick cycles strictly between the rising-edge cycle and the falling-edge cycle. A period result equals the tick cycles strictly between two consecutive rising-edge cycles. The first rising edge after a mode change only starts a measurement.
- R4: A transfer loads the count into the result register and sets `buf_full`. Both are visible one cycle after the completing edge.
- R5: A read with `reg_sel`=1 returns the upper half on `rd_data` one cycle later and snapshots the lower half. A read with `reg_sel`=0 returns that snapshot one cycle later and clears `buf_full`.
- R6: In modes 4'b0001 and 4'b0010, a result completed while `buf_full` is set is discarded and the stored value is kept.
- R7: In mode 4'b1001, a completed high-time result is transferred even while `buf_full` is set.
- R8: In mode 4'b1001, a completed period result is discarded while `buf_full` is set.
- R9: A write with `reg_sel`=1 replaces the upper half of the result, and with `reg_sel`=0 the lower half. `buf_full` is left unchanged.
- R10: If a transfer and a lower-half read fall in the same cycle, `buf_full` remains set.
- R11: After reset the result, `rd_data` and `buf_full` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_in | input | 1 | Measured signal, synchronous to clk |
| tick | input | 1 | Count enable for the measurement counter |
| mode_sel | input | 4 | Measurement mode code |
| reg_rd | input | 1 | Read strobe for the result register |
| reg_wr | input | 1 | Write strobe for the result register |
| reg_sel | input | 1 | Half select: 1 upper, 0 lower |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered |
| buf_full | output | 1 | Unread result present |

## Verification
Each result lands in the register on the clock edge where the closing input edge is seen. `buf_full` rises on that same edge. A read strobe shows its half on `rd_data` one edge later, and a lower-half read drops the flag on that edge. The bench therefore drives every input at the falling clock edge and samples 1 ns after the rising edge that completes the step. It predicts each count by tallying its own tick pulses between the bench's own input edges. Sweeps over high time, low time and tick spacing run on a 4-bit-half configuration, so saturation of the counter is reached within a few hundred cycles.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    PM_IDLE  = 2'd0,
    PM_HIGH  = 2'd1,
    PM_CYCLE = 2'd2,
    PM_BOTH  = 2'd3
  } pm_e;

  localparam logic [3:0] MODE_CODE_HIGH  = 4'b0001;
  localparam logic [3:0] MODE_CODE_CYCLE = 4'b0010;
  localparam logic [3:0] MODE_CODE_BOTH  = 4'b1001;

  // map the external mode code onto the internal measurement kind
  function automatic pm_e decode_mode(input logic [3:0] code);
    case (code)
      MODE_CODE_HIGH:  return PM_HIGH;
      MODE_CODE_CYCLE: return PM_CYCLE;
      MODE_CODE_BOTH:  return PM_BOTH;
      default:         return PM_IDLE;
    endcase
  endfunction

  function automatic logic wants_high(input pm_e m);
    return (m == PM_HIGH) || (m == PM_BOTH);
  endfunction

  function automatic logic wants_cycle(input pm_e m);
    return (m == PM_CYCLE) || (m == PM_BOTH);
  endfunction

  // transfer permitted when empty, or when the result overrides the interlock
  function automatic logic may_transfer(input logic full, input logic forced);
    return !full || forced;
  endfunction

endpackage

// File: rtl/pwc_edge_track.sv
module pwc_edge_track
  import pwc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic meas_in,
  input  pm_e  mode,
  input  logic mode_chg,
  output logic rise_ev,
  output logic high_done,
  output logic cyc_done
);

  logic meas_q;
  logic armed;
  logic in_high;
  logic active;
  logic rise_raw;
  logic fall_raw;

  assign rise_raw  = meas_in & ~meas_q;
  assign fall_raw  = ~meas_in & meas_q;
  assign active    = (mode != PM_IDLE) && !mode_chg;
  assign rise_ev   = active && rise_raw;
  assign high_done = active && fall_raw && in_high && wants_high(mode);
  assign cyc_done  = rise_ev && armed && wants_cycle(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_q  <= 1'b0;
      armed   <= 1'b0;
      in_high <= 1'b0;
    end else begin
      meas_q <= meas_in;
      if (!active) begin
        armed   <= 1'b0;
        in_high <= 1'b0;
      end else if (rise_raw) begin
        armed   <= 1'b1;
        in_high <= 1'b1;
      end else if (fall_raw) begin
        in_high <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= sat_inc(cnt);
  end

endmodule

// File: rtl/pwc_result.sv
module pwc_result #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [CNT_W-1:0]  cap_val,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic              rd_lo,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  result,
  output logic              buf_full
);

  logic [DATA_W-1:0] lo_snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
    end else if (xfer) begin
      result <= cap_val;
    end else if (reg_wr) begin
      if (reg_sel) result[CNT_W-1:DATA_W] <= wr_data;
      else         result[DATA_W-1:0]     <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      buf_full <= 1'b0;
    else if (xfer)   buf_full <= 1'b1;
    else if (rd_lo)  buf_full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      lo_snap <= '0;
    end else if (reg_rd) begin
      if (reg_sel) begin
        rd_data <= result[CNT_W-1:DATA_W];
        lo_snap <= result[DATA_W-1:0];
      end else begin
        rd_data <= lo_snap;
      end
    end
  end

endmodule

// File: rtl/pwc_capture.sv
module pwc_capture
  import pwc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_in,
  input  logic              tick,
  input  logic [3:0]        mode_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full
);

  localparam int CNT_W = 2 * DATA_W;

  logic [3:0]       mode_q;
  logic             mode_chg;
  pm_e              mode;
  logic             rise_ev;
  logic             high_done;
  logic             cyc_done;
  logic             forced;
  logic             xfer;
  logic             rd_lo;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] result;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_sel;
  end

  assign mode     = decode_mode(mode_sel);
  assign mode_chg = (mode_sel != mode_q);
  assign forced   = high_done && (mode == PM_BOTH);
  assign xfer     = (high_done || cyc_done) && may_transfer(buf_full, forced);
  assign rd_lo    = reg_rd && !reg_sel;

  pwc_edge_track u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_in   (meas_in),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .rise_ev   (rise_ev),
    .high_done (high_done),
    .cyc_done  (cyc_done)
  );

  pwc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rise_ev),
    .tick    (tick),
    .cnt     (cnt)
  );

  pwc_result #(.DATA_W(DATA_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (xfer),
    .cap_val  (cnt),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .rd_lo    (rd_lo),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .result   (result),
    .buf_full (buf_full)
  );

endmodule

// File: rtl/pwc_capture_chk.sv
module pwc_capture_chk
  import pwc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] wr_data,
  input pm_e               mode,
  input logic              rise_ev,
  input logic              high_done,
  input logic              cyc_done,
  input logic              xfer,
  input logic              rd_lo,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  result,
  input logic              buf_full
);

  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> cnt == '0);

  a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ev && tick && cnt != {CNT_W{1'b1}}) |=> cnt == $past(cnt) + 1'b1);

  a_r1_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ev && cnt == {CNT_W{1'b1}}) |=> cnt == {CNT_W{1'b1}});

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_IDLE) |-> !(high_done || cyc_done));

  a_r4_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (buf_full && result == $past(cnt)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !xfer) |=> !buf_full);

  a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ((high_done || cyc_done) && buf_full && mode != PM_BOTH && !reg_wr) |=> $stable(result));

  a_r7_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (high_done && mode == PM_BOTH) |=> (buf_full && result == $past(cnt)));

  a_r8_cycle_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && buf_full && mode == PM_BOTH && !reg_wr) |=> $stable(result));

  a_r9_write_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !xfer) |=> result[CNT_W-1:DATA_W] == $past(wr_data));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && rd_lo) |=> buf_full);

  a_r4_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_full && !xfer) |=> !buf_full);

endmodule

bind pwc_capture pwc_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .wr_data   (wr_data),
  .mode      (mode),
  .rise_ev   (rise_ev),
  .high_done (high_done),
  .cyc_done  (cyc_done),
  .xfer      (xfer),
  .rd_lo     (rd_lo),
  .cnt       (cnt),
  .result    (result),
  .buf_full  (buf_full)
);

// File: tb/pwc_capture_test.sv
`timescale 1ns/1ps
module pwc_capture_test;

  localparam int DW   = 4;
  localparam int CMAX = 255;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          meas_in = 1'b0;
  logic          tick = 1'b0;
  logic [3:0]    mode_sel = 4'b0000;
  logic          reg_rd = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          buf_full;

  int checks = 0;
  int errors = 0;
  int tick_period = 1;
  bit tick_on = 1'b1;
  int phase = 0;
  logic prev_meas = 1'b0;
  int since_rise = 0;
  int exp_high = 0;
  int exp_cyc = 0;

  always #2.5 clk = ~clk;

  pwc_capture #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .meas_in(meas_in), .tick(tick),
    .mode_sel(mode_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .buf_full(buf_full)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock step; the bench tallies ticks between its own input edges
  task automatic step(input logic m, input logic rd, input logic sel,
                      input logic wr, input logic [DW-1:0] wd);
    logic t;
    @(negedge clk);
    t = tick_on && ((phase % tick_period) == 0);
    phase++;
    meas_in = m; tick = t; reg_rd = rd; reg_sel = sel; reg_wr = wr; wr_data = wd;
    if (m && !prev_meas) begin
      exp_cyc = since_rise;
      since_rise = 0;
    end else begin
      if (!m && prev_meas) exp_high = since_rise;
      if (t && since_rise < CMAX) since_rise++;
    end
    prev_meas = m;
    @(posedge clk);
    #1;
  endtask

  task automatic hold(input logic m, input int n);
    for (int i = 0; i < n; i++) step(m, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic pulse(input int hi, input int lo);
    hold(1'b1, hi);
    hold(1'b0, lo);
  endtask

  task automatic set_mode(input logic [3:0] code);
    @(negedge clk);
    mode_sel = code;
    hold(prev_meas, 2);
  endtask

  task automatic rd16(output int v);
    logic [DW-1:0] hi;
    step(prev_meas, 1'b1, 1'b1, 1'b0, '0);
    hi = rd_data;
    step(prev_meas, 1'b1, 1'b0, 1'b0, '0);
    v = int'({hi, rd_data});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int h1;
    int h3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(buf_full == 1'b0, "R11 flag", int'(buf_full), 0);
    check(rd_data == '0, "R11 rd_data", int'(rd_data), 0);
    rd16(v);
    check(v == 0, "R11 result", v, 0);

    // R2: idle code gives no results
    pulse(3, 3); pulse(2, 4);
    check(buf_full == 1'b0, "R2 idle", int'(buf_full), 0);
    set_mode(4'b0111);
    pulse(3, 3); pulse(4, 2);
    check(buf_full == 1'b0, "R2 unused code", int'(buf_full), 0);

    // R3/R4/R5: high-time sweep over tick spacing
    set_mode(4'b0001);
    for (int p = 1; p <= 3; p++) begin
      tick_period = p;
      for (int h = 1; h <= 8; h++) begin
        pulse(h, 2);
        check(buf_full == 1'b1, "R4 flag set", int'(buf_full), 1);
        rd16(v);
        check(v == exp_high, "R3 high time", v, exp_high);
        check(buf_full == 1'b0, "R5 flag cleared", int'(buf_full), 0);
      end
    end

    // R3: period sweep; first rise only arms
    tick_period = 1;
    set_mode(4'b0010);
    pulse(2, 2);
    check(buf_full == 1'b0, "R3 first rise arms only", int'(buf_full), 0);
    for (int p = 1; p <= 2; p++) begin
      tick_period = p;
      for (int h = 1; h <= 4; h++) begin
        for (int l = 1; l <= 4; l++) begin
          hold(1'b1, 1);
          rd16(v);
          check(v == exp_cyc, "R3 period", v, exp_cyc);
          check(buf_full == 1'b0, "R5 flag cleared", int'(buf_full), 0);
          hold(1'b1, h);
          hold(1'b0, l);
        end
      end
    end

    // R6: second high result dropped while full
    tick_period = 1;
    set_mode(4'b0001);
    pulse(3, 2);
    h1 = exp_high;
    pulse(6, 2);
    check(exp_high != h1, "R6 setup", exp_high, h1);
    rd16(v);
    check(v == h1, "R6 kept first", v, h1);

    // R6: period result dropped while full
    set_mode(4'b0010);
    pulse(2, 2);
    hold(1'b1, 1);
    h1 = exp_cyc;
    hold(1'b1, 4); hold(1'b0, 3);
    hold(1'b1, 1);
    rd16(v);
    check(v == h1, "R6 period kept", v, h1);

    // R8: combined mode, period blocked while full
    set_mode(4'b1001);
    hold(1'b0, 2);
    pulse(4, 3);
    h1 = exp_high;
    check(buf_full == 1'b1, "R4 combined high", int'(buf_full), 1);
    hold(1'b1, 1);
    rd16(v);
    check(v == h1, "R8 period discarded", v, h1);
    hold(1'b1, 3); hold(1'b0, 3);
    check(buf_full == 1'b1, "R4 combined high 2", int'(buf_full), 1);
    // R7: high result overrides full flag
    hold(1'b1, 7); hold(1'b0, 2);
    rd16(v);
    check(v == exp_high, "R7 forced high", v, exp_high);
    // normal combined flow: period after high has been read
    hold(1'b1, 1);
    rd16(v);
    check(v == exp_cyc, "R3 combined period", v, exp_cyc);

    // R10: forced transfer coincides with lower-half read
    hold(1'b1, 2); hold(1'b0, 2);
    h3 = exp_high;
    hold(1'b1, 3);
    step(1'b1, 1'b1, 1'b1, 1'b0, '0);
    check(int'(rd_data) == (h3 >> DW), "R5 upper half", int'(rd_data), h3 >> DW);
    step(1'b0, 1'b1, 1'b0, 1'b0, '0);
    check(int'(rd_data) == (h3 & 15), "R5 lower snapshot", int'(rd_data), h3 & 15);
    check(buf_full == 1'b1, "R10 set wins", int'(buf_full), 1);
    rd16(v);
    check(v == exp_high, "R7 same-cycle result", v, exp_high);

    // R9: bus writes
    set_mode(4'b0001);
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'hA);
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'h5);
    check(buf_full == 1'b0, "R9 flag untouched", int'(buf_full), 0);
    rd16(v);
    check(v == 8'hA5, "R9 write both", v, 8'hA5);
    pulse(9, 2);
    h1 = exp_high;
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'h3);
    check(buf_full == 1'b1, "R9 flag kept", int'(buf_full), 1);
    rd16(v);
    check(v == ((h1 & 8'hF0) | 3), "R9 lower write", v, (h1 & 8'hF0) | 3);

    // R1: saturation and tick gating
    pulse(300, 2);
    rd16(v);
    check(v == CMAX, "R1 saturate", v, CMAX);
    tick_on = 1'b0;
    pulse(6, 2);
    rd16(v);
    check(v == 0, "R1 no tick", v, 0);
    tick_on = 1'b1;

    // R2: mode change abandons a pulse in progress
    hold(1'b1, 3);
    set_mode(4'b0010);
    set_mode(4'b0001);
    hold(1'b1, 2); hold(1'b0, 3);
    check(buf_full == 1'b0, "R2 mode change discards", int'(buf_full), 0);
    pulse(5, 2);
    rd16(v);
    check(v == exp_high, "R2 resumes", v, exp_high);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule